// File: doc/BRIEF.md
# Logical-to-physical pin crossbar

This block connects eight logical signal lanes to a field of up to 128 physical pads. Each lane has one mapping entry that holds a valid flag and a pad index, so any lane can be placed on any pad. A small write-only register port loads these entries and also loads a peripheral-select code. The code decides which internal peripheral is allowed to drive the lanes. Each peripheral gives the lane numbers its own fixed roles. For example, with the SPI master active lanes 0 to 3 carry MOSI, MISO, SCLK and SSEL. With the UART active the same lanes carry TX, RX, CTS and RTS.

Every peripheral sees every lane's input. Those inputs come from the mapped pad through a two-flop synchronizer. Output value and output enable are different: they reach a pad only when all of these hold:
- the pad is claimed by a valid lane mapping;
- that lane belongs to the role set of the active peripheral;
- the active peripheral asserts the lane's output enable.

Every other pad stays high-impedance. A full reset tristates everything and clears all mappings. A separate peripheral reset only drops the select code back to "none" and leaves the mappings in place.

Top module: `pin_xbar`

## Requirements
- R1: While `rstN` is low, and after it rises, every pad has `padOe` = 0, `padOut` = 0 and `laneIn` = 0. All mapping entries are invalid and the select code is 0. Selecting a peripheral after reset still drives no pad until a mapping is written.
- R2: A write with `regWe` = 1 to address L (0 to 7) loads lane L's entry in the next cycle. `regWdata` bit 7 is the valid flag and bits 6:0 are the pad index. Writes to addresses 9 to 15 change nothing observable.
- R3: A write to address 8 loads the select code from `regWdata` bits 2:0, and it takes effect in the next cycle.
- R4: The select codes are GPIO = 1, SPI master = 2, UART = 4, I2C = 5 and SPI slave = 6. They pick source slots 0, 1, 2, 3 and 4 of `srcOut`/`srcOe`, where slot s occupies bits 8s+7:8s. Codes 0, 3 and 7 drive no pad.
- R5: A peripheral drives only the lanes in its role set:
  - GPIO: lanes 0 to 7;
  - SPI master, UART and SPI slave: lanes 0 to 3;
  - I2C: lanes 0 and 1.

  Its other lanes never drive a pad.
- R6: A pad claimed by a valid lane has `padOe` equal to the active slot's output enable for that lane, and `padOut` equal to that slot's value gated by the enable. In GPIO mode each lane's value and drive bits act independently. An unclaimed pad has `padOe` = 0 and `padOut` = 0.
- R7: When two valid lanes name the same pad, the lower-numbered lane owns it, even if that lane is not driving.
- R8: `laneIn[L]` equals `padIn` at lane L's mapped pad as sampled two clock edges earlier. It is 0 for an invalid entry, and it does not depend on the select code.
- R9: A one-cycle `periphRst` pulse clears the select code to 0 in the next cycle and keeps all mappings. If it coincides with a select write, the clear wins.
- R10: An entry written with the valid flag at 0 claims no pad, even when its index names a pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphRst | input | 1 | Synchronous peripheral reset; clears the select code only |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address: 0 to 7 are lane entries, 8 is the select code |
| regWdata | input | 8 | Write data |
| srcOut | input | 40 | Lane output values, eight bits per source slot |
| srcOe | input | 40 | Lane output enables, eight bits per source slot |
| padIn | input | 128 | Pad input levels |
| padOut | output | 128 | Pad output values |
| padOe | output | 128 | Pad output enables; 0 means high-impedance |
| laneIn | output | 8 | Synchronized lane inputs, seen by all peripherals |

## Verification
The assertions assume two things about the write side:
- `regWe` and `regAddr` are stable across each sampling edge;
- `periphRst` is a synchronous pulse.

The bench meets both by changing every input only on the falling clock edge. The assertions also assume that `padIn` may change in any cycle without a setup relation, which is why a lane's input is only checked two edges after its pad changed. The stimulus holds the source enables and values constant while the select table is walked. Each pad observation is therefore caused by the select and mapping state alone.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;

  localparam int LANES = 8;
  localparam int SRC_N = 5;
  localparam int SEL_W = 3;

  // Strobes from the register decode to the datapath
  typedef struct packed {
    logic [LANES-1:0] mapWe;
    logic             selWe;
    logic             selClr;
  } xbarStrobe_t;

  // Select code -> one-hot source slot; unknown codes give zero
  function automatic logic [SRC_N-1:0] decodeSel(input logic [SEL_W-1:0] code);
    logic [SRC_N-1:0] hot;
    hot = '0;
    case (code)
      3'd1: hot[0] = 1'b1; // GPIO
      3'd2: hot[1] = 1'b1; // SPI master
      3'd4: hot[2] = 1'b1; // UART
      3'd5: hot[3] = 1'b1; // I2C
      3'd6: hot[4] = 1'b1; // SPI slave
      default: hot = '0;
    endcase
    return hot;
  endfunction

  // Lanes owned by each source slot
  function automatic logic [LANES-1:0] roleMask(input int slot);
    logic [LANES-1:0] m;
    case (slot)
      0:       m = 8'hFF;
      3:       m = 8'h03;
      1, 2, 4: m = 8'h0F;
      default: m = 8'h00;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pin_xbar_ctrl.sv
module pin_xbar_ctrl
  import pin_xbar_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periphRst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output xbarStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(LANES);

  always_comb begin
    strobe = '0;
    for (int l = 0; l < LANES; l++) begin
      strobe.mapWe[l] = regWe && (regAddr == ADDR_W'(l));
    end
    strobe.selWe  = regWe && (regAddr == SEL_ADDR);
    strobe.selClr = periphRst;
  end

  // R2: at most one register is targeted by a write
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.mapWe, strobe.selWe}));

  // R2: writes above the select address raise no strobe
  assert_high_addr_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr > SEL_ADDR) |-> (strobe.mapWe == '0 && !strobe.selWe));

endmodule

// File: rtl/pin_xbar_dp.sv
module pin_xbar_dp
  import pin_xbar_pkg::*;
#(
  parameter int PADS   = 128,
  parameter int IDX_W  = $clog2(PADS),
  parameter int DATA_W = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xbarStrobe_t            strobe,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [SRC_N*LANES-1:0] srcOut,
  input  logic [SRC_N*LANES-1:0] srcOe,
  input  logic [PADS-1:0]        padIn,
  output logic [PADS-1:0]        padOut,
  output logic [PADS-1:0]        padOe,
  output logic [LANES-1:0]       laneIn
);

  logic [LANES-1:0] mapValid;
  logic [IDX_W-1:0] mapIdx [LANES];
  logic [SEL_W-1:0] selCode;
  logic [PADS-1:0]  syncA, syncB;
  logic [SRC_N-1:0] slotHot;
  logic [LANES-1:0] laneOe, laneVal;

  // Mapping table and select register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapValid <= '0;
      for (int l = 0; l < LANES; l++) mapIdx[l] <= '0;
      selCode <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (strobe.mapWe[l]) begin
          mapValid[l] <= wdata[DATA_W-1];
          mapIdx[l]   <= wdata[IDX_W-1:0];
        end
      end
      if (strobe.selClr)     selCode <= '0;
      else if (strobe.selWe) selCode <= wdata[SEL_W-1:0];
    end
  end

  // Input synchronizer on every pad
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // Lane drivers from the active source, limited to its role set
  always_comb begin
    slotHot = decodeSel(selCode);
    laneOe  = '0;
    laneVal = '0;
    for (int s = 0; s < SRC_N; s++) begin
      if (slotHot[s]) begin
        laneOe  = srcOe[s*LANES +: LANES]  & roleMask(s);
        laneVal = srcOut[s*LANES +: LANES] & roleMask(s);
      end
    end
  end

  // Per-pad ownership: lowest valid lane naming the pad wins
  for (genvar p = 0; p < PADS; p++) begin : g_pad
    logic oeP, valP;
    always_comb begin
      oeP  = 1'b0;
      valP = 1'b0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (mapValid[l] && mapIdx[l] == IDX_W'(p)) begin
          oeP  = laneOe[l];
          valP = laneVal[l];
        end
      end
    end
    assign padOe[p]  = oeP;
    assign padOut[p] = oeP & valP;
  end

  // Lane inputs from the synchronized mapped pad
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneIn[l] = mapValid[l] ? syncB[mapIdx[l]] : 1'b0;

    // R2: entry holds the written flag and index
    assert_map_load_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.mapWe[l] |=> (mapValid[l] == $past(wdata[DATA_W-1]) &&
                           mapIdx[l] == $past(wdata[IDX_W-1:0])));
  end

  // R1: pads are quiet on the first edge after reset release
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && laneIn == '0));

  // R4: an unknown select code drives no pad
  assert_unknown_sel_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slotHot == '0) |-> (padOe == '0));

  // R6: never more driven pads than lanes, and no value without enable
  assert_pad_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(padOe) <= LANES) && ((padOut & ~padOe) == '0));

  // R9: peripheral reset clears the select and keeps the table
  assert_periph_reset_keeps_map_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selClr && strobe.mapWe == '0) |=> (selCode == '0 && $stable(mapValid)));

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int PADS   = 128,
  parameter int ADDR_W = 4,
  localparam int IDX_W  = $clog2(PADS),
  localparam int DATA_W = IDX_W + 1,
  localparam int SRC_W  = SRC_N * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periphRst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [SRC_W-1:0]  srcOut,
  input  logic [SRC_W-1:0]  srcOe,
  input  logic [PADS-1:0]   padIn,
  output logic [PADS-1:0]   padOut,
  output logic [PADS-1:0]   padOe,
  output logic [LANES-1:0]  laneIn
);

  xbarStrobe_t strobe;

  pin_xbar_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .periphRst (periphRst),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .strobe    (strobe)
  );

  pin_xbar_dp #(.PADS(PADS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (regWdata),
    .srcOut (srcOut),
    .srcOe  (srcOe),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .laneIn (laneIn)
  );

endmodule

// File: tb/tb_pin_xbar.sv
module tb_pin_xbar;

  localparam int CLK_PERIOD = 10;
  localparam int PADS = 128;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         periphRst = 1'b0;
  logic         regWe = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [7:0]   regWdata = '0;
  logic [39:0]  srcOut;
  logic [39:0]  srcOe;
  logic [127:0] padIn = '0;
  logic [127:0] padOut, padOe;
  logic [7:0]   laneIn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // {code, expected enable mask on pads 17:10, expected values there}
  localparam logic [18:0] SEL_VEC [8] = '{
    {3'd0, 8'h00, 8'h00}, {3'd1, 8'hFF, 8'h5A},
    {3'd2, 8'h0F, 8'h0C}, {3'd3, 8'h00, 8'h00},
    {3'd4, 8'h0F, 8'h03}, {3'd5, 8'h03, 8'h02},
    {3'd6, 8'h0F, 8'h09}, {3'd7, 8'h00, 8'h00}};

  pin_xbar dut (
    .clk(clk), .rstN(rstN), .periphRst(periphRst), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .srcOut(srcOut), .srcOe(srcOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .laneIn(laneIn));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 20000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    #1;
  endtask

  function automatic logic [127:0] at10(input logic [7:0] m);
    return 128'(m) << 10;
  endfunction

  initial begin
    srcOut = {8'h09, 8'h02, 8'h03, 8'h0C, 8'h5A};
    srcOe  = '1;
    padIn  = {128{1'b1}};
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", padOe, '0);
    chk("R1 laneIn in reset", 128'(laneIn), '0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 oe after reset", padOe, '0);
    wr(4'd8, 8'd1);
    chk("R1 no mapping after reset", padOe, '0);
    chk("R1 laneIn unmapped", 128'(laneIn), '0);
    padIn = '0;

    for (int l = 0; l < 8; l++) wr(4'(l), 8'h80 | 8'(10 + l));

    // R4 R5 select table walk
    for (int i = 0; i < 8; i++) begin
      wr(4'd8, {5'd0, SEL_VEC[i][18:16]});
      chk($sformatf("R4 R5 oe code %0d", SEL_VEC[i][18:16]), padOe, at10(SEL_VEC[i][15:8]));
      chk($sformatf("R3 R6 out code %0d", SEL_VEC[i][18:16]), padOut, at10(SEL_VEC[i][7:0]));
    end

    // R6 independent GPIO drive bits
    wr(4'd8, 8'd1);
    srcOe[7:0] = 8'h33; #1;
    chk("R6 gpio oe", padOe, at10(8'h33));
    chk("R6 gpio out", padOut, at10(8'h12));

    // R7 collision: lane 5 onto pad 11 owned by lane 1
    wr(4'd5, 8'h80 | 8'd11);
    chk("R7 lower lane wins", padOe, at10(8'h13));
    srcOe[7:0] = 8'h20; #1;
    chk("R7 lower lane wins while idle", padOe, '0);
    wr(4'd5, 8'h80 | 8'd15);
    chk("R2 remap lane5", padOe, at10(8'h20));

    // R10 invalid entry claims nothing
    srcOe[7:0] = 8'hFF;
    wr(4'd3, 8'h0D);
    chk("R10 invalid entry", padOe, at10(8'hF7));

    // R2 high addresses ignored
    wr(4'd9, 8'h80 | 8'd20);
    wr(4'd15, 8'h80 | 8'd21);
    chk("R2 high address ignored", padOe, at10(8'hF7));

    // R5 boundary pads 0 and 127
    wr(4'd6, 8'h80);
    wr(4'd7, 8'hFF);
    chk("R5 R6 edge pads", padOe, at10(8'h37) | 128'h1 | (128'h1 << 127));

    // R8 input synchronizer latency
    @(negedge clk);
    padIn[10] = 1'b1; padIn[13] = 1'b1;
    @(negedge clk); #1;
    chk("R8 one edge: not yet", 128'(laneIn[0]), 128'h0);
    @(negedge clk); #1;
    chk("R8 two edges", 128'(laneIn[0]), 128'h1);
    chk("R8 invalid lane reads 0", 128'(laneIn[3]), 128'h0);
    wr(4'd8, 8'd3);
    chk("R8 observed with no select", 128'(laneIn[0]), 128'h1);

    // R9 peripheral reset keeps mappings
    wr(4'd8, 8'd1);
    @(negedge clk);
    periphRst = 1'b1;
    @(negedge clk);
    periphRst = 1'b0; #1;
    chk("R9 select cleared", padOe, '0);
    wr(4'd8, 8'd1);
    chk("R9 mapping kept", padOe, at10(8'h37) | 128'h1 | (128'h1 << 127));
    @(negedge clk);
    periphRst = 1'b1; regWe = 1'b1; regAddr = 4'd8; regWdata = 8'd1;
    @(negedge clk);
    periphRst = 1'b0; regWe = 1'b0; #1;
    chk("R9 clear beats write", padOe, '0);

    // R1 mid-run reset clears mappings
    wr(4'd8, 8'd1);
    @(negedge clk);
    rstN = 1'b0; #1;
    chk("R1 oe during reset", padOe, '0);
    @(negedge clk);
    rstN = 1'b1;
    wr(4'd8, 8'd1);
    chk("R1 mappings cleared", padOe, '0);

    finish_run();
  end

endmodule